// File: doc/BRIEF.md
# General-Purpose Pin Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port. It sits behind a simple single-cycle register bus with an address, write data, a write strobe and combinational read data. Software can use it to drive pins as outputs, sample pins as inputs, and take one combined interrupt when selected pins meet their trigger condition. Each pin has a direction bit and an output data bit. Three write-only alias addresses change the output data in one bus cycle: one sets the masked bits, one clears them and one inverts them. The bits that are zero in the mask keep their value.

Pin inputs pass through a two-stage synchronizer. The pad status register returns these synchronized levels. Each pin has a two-bit trigger condition: low level, high level, rising edge or falling edge. An any-edge bit overrides that condition. A detected condition sets the pin's status flag whether or not the pin is masked. Software clears a flag by writing one to its bit. The interrupt output is the registered OR, over all pins, of each status flag ANDed with its enable bit.

Top module: `pinport_top`

## Requirements
- R1: While reset is asserted, every register reads zero, and `pin_out`, `pin_oe` and `irq` are zero.
- R2: Address 0 (output data) and address 1 (direction) can be written and read back. `pin_out` equals the output data register. `pin_oe` equals the direction register, where 1 means output.
- R3: A write to address 8 ORs the write data into the output data. A write to address 9 clears the bits that are ones in the write data. A write to address 10 inverts the bits that are ones in the write data. Bits that are zero in the write data keep their value. A read of addresses 8 to 10 returns zero.
- R4: Address 2 returns the pin levels from the two-stage synchronizer. A change on `pin_in` becomes visible after the second rising clock edge, whatever the pin's direction.
- R5: Each pin has a two-bit condition code: 00 low level, 01 high level, 10 rising edge, 11 falling edge. Address 3 holds pins 0 to 15 and address 4 holds pins 16 to 31. Pin n uses bits [2n+1:2n] of its register, with n counted from the first pin of that register.
- R6: In a level mode, the status flag is set on every cycle the synchronized level matches. The flag therefore comes back right after a clear while the level persists.
- R7: In an edge mode, the flag is set only on the selected transition of the synchronized level. A steady level, or the opposite transition, leaves the flag clear.
- R8: When a pin's bit in address 5 (any-edge) is 1, the pin flags on both transitions and its condition code is ignored.
- R9: Address 7 holds the status flags. Writing 1 to a bit clears that flag. Writing 0 leaves the flag unchanged. A detection in the same cycle as a clear wins, and the flag stays set.
- R10: A detection sets its flag whatever the enable bits in address 6 hold. `irq` is 1 one cycle after any flag is 1 while its enable bit is also 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data driven to the pins |
| pin_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The trigger logic is swept over all 32 pins and all five modes: four condition codes and the any-edge override, which is tried with the high-level code underneath. Each pin goes through the same sequence: steady low, rising edge, steady high, falling edge. A clear comes before each steady phase. This sequence tells a level flag that re-asserts apart from an edge flag that stays clear. It also separates a rising detector from a falling one. The whole status word is compared, so a wrong pin index or a wrong condition-register half shows up as a stray bit. A series of set, clear and toggle masks with overlapping bits tests the aliases against a running model. Directed steps test enable gating, clearing with zero bits in the mask, and a detection that coincides with a clear.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    localparam int NPINS   = 32;
    localparam int AW      = 4;
    localparam int CW      = 2;
    localparam int HALF    = NPINS / 2;

    localparam logic [AW-1:0] A_OUT   = 4'd0;
    localparam logic [AW-1:0] A_DIR   = 4'd1;
    localparam logic [AW-1:0] A_PAD   = 4'd2;
    localparam logic [AW-1:0] A_CLO   = 4'd3;
    localparam logic [AW-1:0] A_CHI   = 4'd4;
    localparam logic [AW-1:0] A_ANY   = 4'd5;
    localparam logic [AW-1:0] A_EN    = 4'd6;
    localparam logic [AW-1:0] A_FLAG  = 4'd7;
    localparam logic [AW-1:0] A_SET   = 4'd8;
    localparam logic [AW-1:0] A_CLR   = 4'd9;
    localparam logic [AW-1:0] A_TGL   = 4'd10;

    typedef enum logic [CW-1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

endpackage

// File: rtl/pinport_sync.sv
module pinport_sync
    import pinport_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.stable;
    assign rise  = st_q.stable & ~st_q.prev;
    assign fall  = ~st_q.stable & st_q.prev;

    AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (st_q.prev == $past(level))) else $error("prev mismatch"); // R4

endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [N-1:0]    wdata,
    input  logic            we,
    input  logic [N-1:0]    pad,
    input  logic [N-1:0]    flags,
    output logic [N-1:0]    out_data,
    output logic [N-1:0]    dir,
    output logic [2*N-1:0]  cond,
    output logic [N-1:0]    any_edge,
    output logic [N-1:0]    enable,
    output logic [N-1:0]    clr_mask,
    output logic [N-1:0]    rdata
);

    typedef struct packed {
        logic [N-1:0] outd;
        logic [N-1:0] dir;
        logic [N-1:0] clo;
        logic [N-1:0] chi;
        logic [N-1:0] any;
        logic [N-1:0] en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (addr)
                A_OUT:   r_d.outd = wdata;
                A_DIR:   r_d.dir  = wdata;
                A_CLO:   r_d.clo  = wdata;
                A_CHI:   r_d.chi  = wdata;
                A_ANY:   r_d.any  = wdata;
                A_EN:    r_d.en   = wdata;
                A_SET:   r_d.outd = r_q.outd | wdata;
                A_CLR:   r_d.outd = r_q.outd & ~wdata;
                A_TGL:   r_d.outd = r_q.outd ^ wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            A_OUT:   rdata = r_q.outd;
            A_DIR:   rdata = r_q.dir;
            A_PAD:   rdata = pad;
            A_CLO:   rdata = r_q.clo;
            A_CHI:   rdata = r_q.chi;
            A_ANY:   rdata = r_q.any;
            A_EN:    rdata = r_q.en;
            A_FLAG:  rdata = flags;
            default: rdata = '0;
        endcase
    end

    assign clr_mask = (we && addr == A_FLAG) ? wdata : '0;
    assign out_data = r_q.outd;
    assign dir      = r_q.dir;
    assign cond     = {r_q.chi, r_q.clo};
    assign any_edge = r_q.any;
    assign enable   = r_q.en;

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_SET) |=> ((out_data & $past(wdata)) == $past(wdata))) else $error("set alias"); // R3
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_CLR) |=> ((out_data & $past(wdata)) == '0)) else $error("clear alias"); // R3
    AST_TGL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_TGL) |=> (((out_data ^ $past(out_data)) & ~$past(wdata)) == '0)) else $error("toggle alias"); // R3

endmodule

// File: rtl/pinport_irq.sv
module pinport_irq
    import pinport_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    level,
    input  logic [N-1:0]    rise,
    input  logic [N-1:0]    fall,
    input  logic [2*N-1:0]  cond,
    input  logic [N-1:0]    any_edge,
    input  logic [N-1:0]    enable,
    input  logic [N-1:0]    clr_mask,
    output logic [N-1:0]    flags,
    output logic            irq
);

    typedef struct packed {
        logic [N-1:0] flags;
        logic         irq;
    } irq_t;

    irq_t s_d, s_q;
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_pin
        trig_e mode;
        assign mode = trig_e'(cond[CW*i +: CW]);
        always_comb begin
            if (any_edge[i]) begin
                hit[i] = rise[i] | fall[i];
            end else begin
                case (mode)
                    TRIG_LOW:  hit[i] = ~level[i];
                    TRIG_HIGH: hit[i] = level[i];
                    TRIG_RISE: hit[i] = rise[i];
                    default:   hit[i] = fall[i];
                endcase
            end
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.flags = (s_q.flags & ~clr_mask) | hit;
        s_d.irq   = |(s_q.flags & enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags = s_q.flags;
    assign irq   = s_q.irq;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((($past(flags) & ~$past(clr_mask)) & ~flags) == '0)) else $error("flag lost"); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((flags & $past(clr_mask & ~hit)) == '0)) else $error("clear ignored"); // R9
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((flags & $past(hit)) == $past(hit))) else $error("hit dropped"); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((flags & enable) != '0)) else $error("irq without enabled flag"); // R10

endmodule

// File: rtl/pinport_top.sv
module pinport_top
    import pinport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic [NPINS-1:0]    level, rise, fall;
    logic [NPINS-1:0]    flags, any_edge, enable, clr_mask;
    logic [2*NPINS-1:0]  cond;

    pinport_sync #(.N(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pin_in),
        .level  (level),
        .rise   (rise),
        .fall   (fall)
    );

    pinport_regs #(.N(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .we       (bus_we),
        .pad      (level),
        .flags    (flags),
        .out_data (pin_out),
        .dir      (pin_oe),
        .cond     (cond),
        .any_edge (any_edge),
        .enable   (enable),
        .clr_mask (clr_mask),
        .rdata    (bus_rdata)
    );

    pinport_irq #(.N(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .rise     (rise),
        .fall     (fall),
        .cond     (cond),
        .any_edge (any_edge),
        .enable   (enable),
        .clr_mask (clr_mask),
        .flags    (flags),
        .irq      (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (!irq && pin_oe == '0)) else $error("reset state"); // R1

endmodule

// File: tb/sim_pinport_top.sv
module sim_pinport_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    pinport_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] v, model, m;
        logic [63:0] cw;
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pin_in = '0;
        idle(3);
        // R1: registers and outputs during reset
        for (int a = 0; a < 11; a++) begin
            rd(4'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;

        // all pins rising-edge, clear flags
        wr(4'd3, 32'hAAAA_AAAA);
        wr(4'd4, 32'hAAAA_AAAA);
        wr(4'd7, 32'hFFFF_FFFF);
        idle(3);
        rd(4'd7, v);
        chk("R7 static clear", v, 0);

        // R2: read-write of output data and direction
        for (int i = 0; i < 4; i++) begin
            m = 32'h1357_9BDF * (i + 1) ^ (32'hF0F0_0F0F >> i);
            wr(4'd0, m);
            wr(4'd1, ~m);
            rd(4'd0, v); chk("R2 out readback", v, m);
            rd(4'd1, v); chk("R2 dir readback", v, ~m);
            chk("R2 pin_out", pin_out, m);
            chk("R2 pin_oe", pin_oe, ~m);
        end

        // R3: alias sequence against a running model
        wr(4'd0, 32'h0F0F_00FF);
        model = 32'h0F0F_00FF;
        for (int i = 0; i < 12; i++) begin
            m = (32'h0000_FFFF << (i * 3)) ^ (32'h8421_8421 >> i);
            case (i % 3)
                0: begin wr(4'd8,  m); model = model | m;  end
                1: begin wr(4'd9,  m); model = model & ~m; end
                default: begin wr(4'd10, m); model = model ^ m; end
            endcase
            chk("R3 alias pin_out", pin_out, model);
            rd(4'd0, v); chk("R3 alias readback", v, model);
            rd(4'(8 + i % 3), v); chk("R3 alias reads zero", v, 0);
        end

        // R4: pad status timing, independent of direction
        wr(4'd1, 32'hFFFF_0000);
        wr(4'd7, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) begin
            m = 32'hA5C3_0F96 ^ (32'h1111_1111 * i);
            rd(4'd2, v);
            pin_in = m;
            model = v;
            idle(1); rd(4'd2, v); chk("R4 pad after one edge", v, model);
            idle(1); rd(4'd2, v); chk("R4 pad after two edges", v, m);
        end
        pin_in = '0;
        idle(4);
        wr(4'd7, 32'hFFFF_FFFF);
        idle(2);

        // R5..R8: sweep of every pin and every mode
        for (int p = 0; p < 32; p++) begin
            for (int md = 0; md < 5; md++) begin
                cw = {32{2'b10}};
                cw[2*p +: 2] = (md == 4) ? 2'b01 : 2'(md);
                wr(4'd3, cw[31:0]);
                wr(4'd4, cw[63:32]);
                wr(4'd5, (md == 4) ? (32'h1 << p) : 32'h0);
                idle(2);
                wr(4'd7, 32'hFFFF_FFFF);
                idle(3);
                rd(4'd7, v);
                chk("R6 steady low after clear (R5 field)", v, (md == 0) ? (32'h1 << p) : 0);
                pin_in[p] = 1'b1;
                idle(4);
                rd(4'd7, v);
                chk("R7 rising transition (R8 any-edge)", v, (md != 3) ? (32'h1 << p) : 0);
                wr(4'd7, 32'hFFFF_FFFF);
                idle(3);
                rd(4'd7, v);
                chk("R6 steady high after clear (R8 ignores code)", v, (md == 1) ? (32'h1 << p) : 0);
                pin_in[p] = 1'b0;
                idle(4);
                rd(4'd7, v);
                chk("R7 falling transition (R8 any-edge)", v, (md != 2) ? (32'h1 << p) : 0);
                wr(4'd3, 32'hAAAA_AAAA);
                wr(4'd4, 32'hAAAA_AAAA);
                wr(4'd5, 32'h0);
                wr(4'd7, 32'hFFFF_FFFF);
                idle(2);
            end
        end

        // R9, R10: clearing, enable gating, interrupt timing
        pin_in[5] = 1'b1;
        idle(4);
        rd(4'd7, v); chk("R10 flag set while disabled", v, 32'h20);
        chk("R10 irq low while disabled", {31'd0, irq}, 0);
        wr(4'd7, ~32'h20);
        rd(4'd7, v); chk("R9 zero bits leave flag", v, 32'h20);
        wr(4'd6, 32'h0000_0020);
        chk("R10 irq not yet", {31'd0, irq}, 0);
        idle(1);
        chk("R10 irq one cycle later", {31'd0, irq}, 1);
        wr(4'd6, 32'hFFFF_FFDF);
        idle(1);
        chk("R10 irq off with other enables", {31'd0, irq}, 0);
        wr(4'd6, 32'h0000_0020);
        idle(1);
        wr(4'd7, 32'h20);
        rd(4'd7, v); chk("R9 write one clears", v, 0);
        idle(1);
        chk("R10 irq drops after clear", {31'd0, irq}, 0);
        cw = {32{2'b10}};
        cw[11:10] = 2'b01;
        wr(4'd3, cw[31:0]);
        idle(3);
        wr(4'd7, 32'h20);
        rd(4'd7, v); chk("R9 detection beats clear", v, 32'h20);
        idle(1);
        chk("R10 irq from level flag", {31'd0, irq}, 1);

        finish_run();
    end

endmodule